// File: doc/BRIEF.md
# Sparsified Pixel Hit Readout with Token Skipping

This block is the digital readout of a small pixel matrix that runs in two separate phases. While `phase_rd` is low (detection), a peripheral 5-bit time-stamp counter advances on every clock and is broadcast to every pixel. A pixel whose hit strobe is high on a clock edge stores the count at that edge. Each pixel holds at most two hits, and each hit keeps its own time stamp.

While `phase_rd` is high (readout), nothing is recorded. A rising edge on `token_in` starts a scan. A priority token passes combinationally over pixels that hold no hit or are masked, and lands on the lowest-numbered pixel that holds one. That pixel's oldest hit is shifted out MSB first on `data_out` as a 24-bit word made of column, row and time stamp. One word occupies one cell period of 24 clocks. A lookahead chain picks the next word in the same cycle, so words follow each other with no idle clock. After the last word, `token_out` rises.

`master_rst` clears every stored hit. `kill_i` masks pixels so that they neither record nor take the token. The readout clock and the cell period share the single clock `clk`: a cell period is 24 `clk` cycles.

Top module: `pxro_top`

## Requirements
- R1: Hit strobes are recorded only while `phase_rd` is 0; strobes that arrive while `phase_rd` is 1 are never stored or reported.
- R2: A pixel stores up to two hits, each with its own 5-bit time stamp, reported oldest first; a strobe on a pixel that already holds two hits is ignored.
- R3: After `rst_n` is released the time-stamp counter starts at 0, advances by one on each clock edge with `phase_rd` 0, and wraps modulo 32; a hit stores the counter value at the edge on which its strobe is sampled.
- R4: Each word is 24 bits sent MSB first: bits 23:16 hold the column (pixel index mod COLS), bits 15:8 the row (pixel index div COLS), bits 7:3 the time stamp and bits 2:0 zero.
- R5: A scan starts only on a rising edge of `token_in` while `phase_rd` is 1; bit 23 of the first word is on `data_out` after that edge, and `data_out` is 0 whenever no word is being shifted.
- R6: Each stored hit takes exactly 24 clocks, and words follow back to back. Pixels are served in ascending index order, and a pixel with no hit takes no clock.
- R7: A pixel whose `kill_i` bit is 1 records no hit and is skipped by the token.
- R8: While `master_rst` is 1, all stored hits are cleared on each clock edge, and a strobe on that same edge is not recorded.
- R9: `token_out` rises exactly 24·N clocks after the start edge, where N is the number of stored unmasked hits. It stays high until `token_in` falls or `phase_rd` returns to 0.
- R10: During and right after reset, `data_out` and `token_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout bit clock; also clocks detection |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_rst | input | 1 | Synchronous clear of all stored hits |
| phase_rd | input | 1 | 0 = detection phase, 1 = readout phase |
| token_in | input | 1 | Scan start; its rising edge begins readout |
| hit_i | input | COLS*ROWS | Per-pixel hit strobes |
| kill_i | input | COLS*ROWS | Per-pixel mask; 1 disables the pixel |
| data_out | output | 1 | Serial hit words, MSB first |
| token_out | output | 1 | High once every stored hit has been sent |

## Verification
The bench keeps its own count of detection clocks and its own per-pixel hit store, and from these it predicts every word and the cycle at which `token_out` rises. The main function is tried with the following patterns:
- an empty matrix, which isolates the no-hit token pass;
- a single hit on pixel 0, which isolates the word format;
- a sweep that hits each pixel once at staggered times, which separates the ordering by address from the ordering by time;
- repeated strobes on the same pixels, which exercise the two-entry store and its overflow;
- a late hit after more than 32 detection clocks, which exposes the counter wrap;
- sparse pseudo-random patterns over many cycles, which mix single, double and empty pixels.

Separate runs place hits on killed pixels, strobe during the readout phase, and assert the master reset, some of them together with a strobe. In each of these runs the hits must not appear in the serial stream.

// File: rtl/pxro_pkg.sv
package pxro_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SHIFT = 2'd1,
        SQ_DONE  = 2'd2
    } seq_e;
endpackage

// File: rtl/pxro_cell.sv
module pxro_cell #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            rec_en,
    input  logic            hit,
    input  logic [TS_W-1:0] ts_in,
    input  logic            pop,
    output logic            pend_o,
    output logic            has2_o,
    output logic [TS_W-1:0] ts_old_o,
    output logic [TS_W-1:0] ts_new_o
);
    typedef struct packed {
        logic [1:0]      cnt;
        logic [TS_W-1:0] t0;
        logic [TS_W-1:0] t1;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (clr) begin
            cell_d.cnt = 2'd0;
        end else if (pop) begin
            if (cell_q.cnt == 2'd2) begin
                cell_d.cnt = 2'd1;
                cell_d.t0  = cell_q.t1;
            end else begin
                cell_d.cnt = 2'd0;
            end
        end else if (rec_en && hit) begin
            if (cell_q.cnt == 2'd0) begin
                cell_d.t0  = ts_in;
                cell_d.cnt = 2'd1;
            end else if (cell_q.cnt == 2'd1) begin
                cell_d.t1  = ts_in;
                cell_d.cnt = 2'd2;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign pend_o   = (cell_q.cnt != 2'd0);
    assign has2_o   = (cell_q.cnt == 2'd2);
    assign ts_old_o = cell_q.t0;
    assign ts_new_o = cell_q.t1;

    // R2
    cnt_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cell_q.cnt <= 2'd2);
    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q.cnt == 2'd2 && !pop && !clr) |=> (cell_q.cnt == 2'd2));
    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_en && !pop && !clr) |=> $stable(cell_q));
    // R6
    pop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cell_q.cnt != 2'd0));
endmodule

// File: rtl/pxro_chain.sv
module pxro_chain #(
    parameter  int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] blk;
    assign blk[0] = 1'b0;

    for (genvar g = 0; g < N; g++) begin : g_link
        assign gnt[g]   = req[g] & ~blk[g];
        assign blk[g+1] = blk[g] | req[g];
    end

    assign any = blk[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = IW'(i);
        end
    end

    // R6
    always_comb begin
        gnt_onehot_chk: assert ($onehot0(gnt));
    end
endmodule

// File: rtl/pxro_top.sv
module pxro_top
    import pxro_pkg::*;
#(
    parameter  int COLS   = 4,
    parameter  int ROWS   = 4,
    parameter  int TS_W   = 5,
    parameter  int ADDR_W = 8,
    parameter  int WORD_W = 24,
    localparam int NPIX   = COLS * ROWS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            master_rst,
    input  logic            phase_rd,
    input  logic            token_in,
    input  logic [NPIX-1:0] hit_i,
    input  logic [NPIX-1:0] kill_i,
    output logic            data_out,
    output logic            token_out
);
    localparam int IW    = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam int PAD_W = WORD_W - 2 * ADDR_W - TS_W;

    typedef struct packed {
        seq_e              st;
        logic              tin;
        logic [TS_W-1:0]   ts;
        logic [BIT_W-1:0]  bitc;
        logic [WORD_W-1:0] sh;
    } seq_t;

    seq_t q, d;
    logic [NPIX-1:0] pop, pend, has2, req_a, req_b, gnt_a, gnt_b;
    logic [TS_W-1:0] ts_old [NPIX];
    logic [TS_W-1:0] ts_new [NPIX];
    logic [IW-1:0]   idx_a, idx_b;
    logic            any_a, any_b;

    function automatic logic [WORD_W-1:0] mk_word(input logic [IW-1:0] p,
                                                  input logic [TS_W-1:0] t);
        mk_word = {ADDR_W'(int'(p) % COLS), ADDR_W'(int'(p) / COLS), t, PAD_W'(0)};
    endfunction

    for (genvar g = 0; g < NPIX; g++) begin : g_cell
        pxro_cell #(.TS_W(TS_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (master_rst),
            .rec_en   (!phase_rd && !kill_i[g]),
            .hit      (hit_i[g]),
            .ts_in    (q.ts),
            .pop      (pop[g]),
            .pend_o   (pend[g]),
            .has2_o   (has2[g]),
            .ts_old_o (ts_old[g]),
            .ts_new_o (ts_new[g])
        );
    end

    assign req_a = pend & ~kill_i;
    assign req_b = req_a & ~gnt_a;

    pxro_chain #(.N(NPIX)) u_chain_now (
        .req (req_a), .gnt (gnt_a), .idx (idx_a), .any (any_a)
    );
    pxro_chain #(.N(NPIX)) u_chain_next (
        .req (req_b), .gnt (gnt_b), .idx (idx_b), .any (any_b)
    );

    always_comb begin
        d     = q;
        pop   = '0;
        d.tin = token_in;
        if (!phase_rd) d.ts = q.ts + TS_W'(1);
        case (q.st)
            SQ_IDLE: begin
                if (phase_rd && token_in && !q.tin) begin
                    if (any_a) begin
                        d.sh   = mk_word(idx_a, ts_old[idx_a]);
                        d.bitc = '0;
                        d.st   = SQ_SHIFT;
                    end else begin
                        d.st = SQ_DONE;
                    end
                end
            end
            SQ_SHIFT: begin
                if (q.bitc == BIT_W'(WORD_W - 1)) begin
                    pop    = gnt_a;
                    d.bitc = '0;
                    if (has2[idx_a]) begin
                        d.sh = mk_word(idx_a, ts_new[idx_a]);
                    end else if (any_b) begin
                        d.sh = mk_word(idx_b, ts_old[idx_b]);
                    end else begin
                        d.st = SQ_DONE;
                    end
                end else begin
                    d.sh   = {q.sh[WORD_W-2:0], 1'b0};
                    d.bitc = q.bitc + BIT_W'(1);
                end
            end
            SQ_DONE: begin
                if (!token_in) d.st = SQ_IDLE;
            end
            default: d.st = SQ_IDLE;
        endcase
        if (!phase_rd || master_rst) begin
            d.st = SQ_IDLE;
            pop  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign data_out  = (q.st == SQ_SHIFT) && q.sh[WORD_W-1];
    assign token_out = (q.st == SQ_DONE);

    // R9
    tok_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_rd |=> !token_out);
    // R8
    mrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_rst |=> (pend == '0));
    // R6
    shift_has_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_SHIFT) |-> (req_a != '0));
    // R1
    no_rec_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_rd && (q.st != SQ_SHIFT || q.bitc != BIT_W'(WORD_W - 1)) && !master_rst)
        |=> $stable(pend));
endmodule

// File: tb/pxro_top_tb.sv
module pxro_top_tb_top;
    localparam int COLS = 4;
    localparam int ROWS = 4;
    localparam int NP   = COLS * ROWS;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, master_rst, phase_rd, token_in;
    logic [NP-1:0] hit, kill;
    logic          data_out, token_out;

    pxro_top #(.COLS(COLS), .ROWS(ROWS)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_rst(master_rst), .phase_rd(phase_rd),
        .token_in(token_in), .hit_i(hit), .kill_i(kill),
        .data_out(data_out), .token_out(token_out)
    );

    int checks = 0;
    int fails  = 0;
    int mcnt [NP];
    logic [4:0] mts [NP][2];
    logic [4:0] tsm;
    logic [15:0] lfsr;

    // bench model of the detection phase
    always @(posedge clk) begin
        if (!rst_n) begin
            tsm = 5'd0;
            for (int p = 0; p < NP; p++) mcnt[p] = 0;
        end else begin
            if (master_rst) begin
                for (int p = 0; p < NP; p++) mcnt[p] = 0;
            end else if (!phase_rd) begin
                for (int p = 0; p < NP; p++) begin
                    if (hit[p] && !kill[p] && mcnt[p] < 2) begin
                        mts[p][mcnt[p]] = tsm;
                        mcnt[p] = mcnt[p] + 1;
                    end
                end
            end
            if (!phase_rd) tsm = tsm + 5'd1;
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hit = '0;
        end
    endtask

    task automatic pulse(input logic [NP-1:0] h);
        @(negedge clk);
        hit = h;
        @(negedge clk);
        hit = '0;
    endtask

    task automatic readout(input string r);
        logic [23:0] w, e;
        @(negedge clk);
        phase_rd = 1'b1;
        hit = '0;
        @(negedge clk);
        token_in = 1'b1;
        @(posedge clk);
        for (int p = 0; p < NP; p++) begin
            if (!kill[p]) begin
                for (int k = 0; k < mcnt[p]; k++) begin
                    w = '0;
                    for (int b = 0; b < 24; b++) begin
                        @(negedge clk);
                        if (b == 0) chk("R9 token low while sending", 32'(token_out), 32'd0);
                        w = {w[22:0], data_out};
                        @(posedge clk);
                    end
                    e = {8'(p % COLS), 8'(p / COLS), mts[p][k], 3'b000};
                    chk(r, 32'(w), 32'(e));
                end
            end
        end
        @(negedge clk);
        chk("R9 token_out after 24*N", 32'(token_out), 32'd1);
        chk("R5 data_out idle", 32'(data_out), 32'd0);
        token_in = 1'b0;
        @(negedge clk);
        chk("R9 token_out falls", 32'(token_out), 32'd0);
        phase_rd = 1'b0;
        for (int p = 0; p < NP; p++) mcnt[p] = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; master_rst = 1'b0; phase_rd = 1'b0; token_in = 1'b0;
        hit = '0; kill = '0; lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        chk("R10 data_out in reset", 32'(data_out), 32'd0);
        chk("R10 token_out in reset", 32'(token_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 token_out after reset", 32'(token_out), 32'd0);

        readout("R9 empty matrix");

        pulse(16'h0001);
        readout("R4 single word");

        for (int p = 0; p < NP; p++) begin
            pulse(NP'(1) << p);
            idle(p % 3);
        end
        readout("R6 sweep order");

        pulse(16'h00F0);
        idle(2);
        pulse(16'h0030);
        pulse(16'h0010);
        readout("R2 double store");

        idle(45);
        pulse(16'h8000);
        pulse(16'h8001);
        readout("R3 counter wrap");

        kill = 16'h0A05;
        pulse(16'hFFFF);
        pulse(16'hFFFF);
        readout("R7 killed pixels");
        kill = '0;

        @(negedge clk);
        phase_rd = 1'b1;
        pulse(16'hFFFF);
        readout("R1 strobes in readout phase");

        pulse(16'hFFFF);
        @(negedge clk);
        master_rst = 1'b1;
        hit = 16'h0003;
        @(negedge clk);
        master_rst = 1'b0;
        hit = '0;
        readout("R8 master reset");

        for (int round = 0; round < 5; round++) begin
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                hit = lfsr & (lfsr >> 5) & (lfsr << 3);
            end
            readout("R6 random pattern");
        end

        finish_run();
    end
endmodule